// File: doc/BRIEF.md
# Latched Programmable Tap Delay Line

This block delays a single-bit stream by a digitally chosen number of clock ticks. The stream enters a tapped shift register. A tap multiplexer picks the output point from a fixed minimum path plus a binary-weighted offset. One nominal gate delay ("unit") is `TICKS_PER_UNIT` ticks, 4 by default. The finest select bit therefore weighs a quarter unit and the coarsest weighs sixteen units.

The select code and a cascade-control bit are held in a clocked latch bank. The bank loads from its bus while the load-enable input is high and keeps its contents while that input is low. Two override inputs act on the bank:
- The minimum override clears every latch.
- The maximum override clears the two lowest code bits, sets every other bit including the cascade bit, and adds one extra unit to the path. The largest setting is then exactly one quarter unit beyond the largest bus code.

A complementary cascade pair reports the latched cascade bit. It lets a second copy of the block extend the range without extra gating. An output-off input forces the output low.

Top module: `pdl_delay_top`

## Requirements
- R1: With no override active, a one-tick pulse on `din` first appears on `dout` FIXED_TAPS + code ticks after the edge that samples it, where code is the latched select value. Bit k of the code adds 2^k ticks (TICKS_PER_UNIT/4 · 2^k in general).
- R2: While `latch_en` is high, the latch bank takes `sel_in` and `casc_in` on each rising clock edge. While it is low, the bank keeps its contents and changes on `sel_in` or `casc_in` have no effect on the delay.
- R3: `casc_hi` equals the latched cascade bit and `casc_lo` is its inverse.
- R4: While `force_min` is high, the code and cascade latches are cleared from the next edge on, the delay is FIXED_TAPS, and the bus is ignored. If the override is released with `latch_en` low, the bank stays cleared.
- R5: While `force_max` is high and `force_min` is low, the code latches hold all ones except bits 0 and 1, the cascade bit is set, and one extra unit is inserted, so the delay is FIXED_TAPS + 128 ticks. After release with `latch_en` low, the pattern is kept but the extra unit is dropped (FIXED_TAPS + 124).
- R6: When both overrides are high, the minimum override wins.
- R7: While `out_off` is high, `dout` is low whatever the delayed stream holds.
- R8: In the two-copy chain, the first copy's `dout` feeds the second copy's `din`, and its `casc_lo` drives the second copy's `force_min`. Setting bit 7 of the combined 8-bit setting sets the first copy's cascade bit and holds its `force_max`. Both copies share `sel_in`. The total delay is 2·FIXED_TAPS + setting for all 256 settings, rising by exactly one tick per step.
- R9: A synchronous active-low reset clears the latches and the delay line, so `dout` is low, `casc_hi` is 0 and `casc_lo` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 1 | Stream to be delayed |
| sel_in | input | SEL_W | Delay select bus |
| casc_in | input | 1 | Cascade-control bit for the latch bank |
| latch_en | input | 1 | Latch bank load enable (high = follow bus) |
| force_min | input | 1 | Minimum-delay override |
| force_max | input | 1 | Maximum-delay override |
| out_off | input | 1 | Output-off gate (high = output low) |
| dout | output | 1 | Delayed stream |
| casc_hi | output | 1 | Latched cascade bit |
| casc_lo | output | 1 | Inverse of the latched cascade bit |

## Verification
A corrupted latch bit shows as a delay that is off by that bit's weight on the next pulse through the line, within FIXED_TAPS + 128 ticks of the pulse. A wrong override priority or a missing extra unit breaks the one-tick staircase of the 256-step chain sweep at the seam where the cascade bit turns on. A wrong cascade output shows there as well, one latch cycle after the bit is loaded.

// File: rtl/pdl_pkg.sv
// Package: shared override encoding for the programmable delay line.
// Assumes: overrides are level inputs sampled on the tick clock.
package pdl_pkg;

    typedef enum logic [1:0] {
        OVR_NONE = 2'd0,
        OVR_MIN  = 2'd1,
        OVR_MAX  = 2'd2
    } ovr_e;

    // Resolve the two force inputs; minimum always wins.
    function automatic ovr_e resolve_ovr(input logic fmin, input logic fmax);
        if (fmin)      return OVR_MIN;
        else if (fmax) return OVR_MAX;
        else           return OVR_NONE;
    endfunction

endpackage

// File: rtl/pdl_ovr_arb.sv
// Module: pdl_ovr_arb
// Turns the minimum/maximum force inputs into one override code.
// Assumes: inputs are synchronous to the tick clock; purely combinational.
module pdl_ovr_arb
    import pdl_pkg::*;
(
    input  logic force_min,
    input  logic force_max,
    output ovr_e ovr
);

    // Priority resolve: minimum before maximum.
    always_comb begin
        ovr = resolve_ovr(force_min, force_max);
    end

endmodule

// File: rtl/pdl_sel_latch.sv
// Module: pdl_sel_latch
// Clocked model of the select/cascade latch bank with set/reset overrides.
// Assumes: latch_en high means "transparent" (loads each edge); low holds.
// The extra-unit flag is active only while the maximum override is held.
module pdl_sel_latch
    import pdl_pkg::*;
#(
    parameter int SEL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_en,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             casc_in,
    input  ovr_e             ovr,
    output logic [SEL_W-1:0] code_q,
    output logic             casc_q,
    output logic             extra_q
);

    localparam logic [SEL_W-1:0] MAX_PAT = {SEL_W{1'b1}} & ~SEL_W'(3);

    // Latch bank update: reset, overrides, load, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            casc_q <= 1'b0;
        end else begin
            unique case (ovr)
                OVR_MIN: begin
                    code_q <= '0;
                    casc_q <= 1'b0;
                end
                OVR_MAX: begin
                    code_q <= MAX_PAT;
                    casc_q <= 1'b1;
                end
                default: begin
                    if (latch_en) begin
                        code_q <= sel_in;
                        casc_q <= casc_in;
                    end
                end
            endcase
        end
    end

    // Extra-unit stage select follows the held maximum override.
    always_ff @(posedge clk) begin
        if (!rst_n) extra_q <= 1'b0;
        else        extra_q <= (ovr == OVR_MAX);
    end

endmodule

// File: rtl/pdl_tap_line.sv
// Module: pdl_tap_line
// Shift register with a tap multiplexer; tap = fixed path + weighted code
// (+ one unit when extra is set).
// Assumes: TICKS_PER_UNIT is a multiple of 4 and FIXED_TAPS >= 1.
module pdl_tap_line #(
    parameter int SEL_W          = 7,
    parameter int TICKS_PER_UNIT = 4,
    parameter int FIXED_TAPS     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [SEL_W-1:0] code,
    input  logic             extra,
    output logic             tap_out
);

    localparam int QTR   = TICKS_PER_UNIT / 4;
    localparam int TAPS  = FIXED_TAPS + QTR * ((1 << SEL_W) - 1) + TICKS_PER_UNIT;
    localparam int IDX_W = $clog2(TAPS);

    logic [TAPS-1:0]  sh;
    logic [IDX_W-1:0] part [SEL_W+1];

    // Base of the tap sum: fixed path plus optional extra unit.
    assign part[0] = IDX_W'(FIXED_TAPS - 1) + (extra ? IDX_W'(TICKS_PER_UNIT) : '0);

    // One binary-weighted stage per select bit.
    for (genvar k = 0; k < SEL_W; k++) begin : g_stage
        assign part[k+1] = part[k] + (code[k] ? IDX_W'(QTR << k) : '0);
    end

    // Delay line: shift one position per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[TAPS-2:0], din};
    end

    // Tap multiplexer.
    always_comb begin
        tap_out = sh[part[SEL_W]];
    end

endmodule

// File: rtl/pdl_delay_top.sv
// Module: pdl_delay_top
// Programmable tap delay line: latch bank, override arbiter, tap line and
// output gate. Cascade pair reports the latched cascade bit.
// Assumes: all inputs synchronous to clk; reset is synchronous active-low.
module pdl_delay_top
    import pdl_pkg::*;
#(
    parameter int SEL_W          = 7,
    parameter int TICKS_PER_UNIT = 4,
    parameter int FIXED_TAPS     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             casc_in,
    input  logic             latch_en,
    input  logic             force_min,
    input  logic             force_max,
    input  logic             out_off,
    output logic             dout,
    output logic             casc_hi,
    output logic             casc_lo
);

    ovr_e             ovr;
    logic [SEL_W-1:0] code_q;
    logic             casc_q;
    logic             extra_q;
    logic             tap_out;

    pdl_ovr_arb u_arb (
        .force_min (force_min),
        .force_max (force_max),
        .ovr       (ovr)
    );

    pdl_sel_latch #(.SEL_W(SEL_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (latch_en),
        .sel_in   (sel_in),
        .casc_in  (casc_in),
        .ovr      (ovr),
        .code_q   (code_q),
        .casc_q   (casc_q),
        .extra_q  (extra_q)
    );

    pdl_tap_line #(
        .SEL_W          (SEL_W),
        .TICKS_PER_UNIT (TICKS_PER_UNIT),
        .FIXED_TAPS     (FIXED_TAPS)
    ) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .code    (code_q),
        .extra   (extra_q),
        .tap_out (tap_out)
    );

    // Output gate and complementary cascade pair.
    always_comb begin
        dout    = tap_out & ~out_off;
        casc_hi = casc_q;
        casc_lo = ~casc_q;
    end

endmodule

// File: rtl/pdl_delay_chk.sv
// Module: pdl_delay_chk
// Assertion checker for pdl_delay_top, attached by bind below.
// Assumes: sees the latched code through the bind connection.
module pdl_delay_chk #(
    parameter int SEL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             latch_en,
    input logic             force_min,
    input logic             force_max,
    input logic             out_off,
    input logic [SEL_W-1:0] sel_in,
    input logic             casc_in,
    input logic [SEL_W-1:0] code_q,
    input logic             casc_hi,
    input logic             dout
);

    localparam logic [SEL_W-1:0] MAX_PAT = {SEL_W{1'b1}} & ~SEL_W'(3);

    // R2: load while enabled.
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && !force_min && !force_max) |=>
            (code_q == $past(sel_in) && casc_hi == $past(casc_in)));

    // R2: hold while disabled.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_en && !force_min && !force_max) |=>
            ($stable(code_q) && $stable(casc_hi)));

    // R4 and R6: minimum override clears the bank.
    p_min_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        force_min |=> (code_q == '0 && !casc_hi));

    // R5: maximum override sets the fixed pattern.
    p_max_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (force_max && !force_min) |=> (code_q == MAX_PAT && casc_hi));

    // R7: output gated off.
    p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_off |-> !dout);

    // R9: reset clears the bank.
    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (code_q == '0 && !casc_hi));

endmodule

bind pdl_delay_top pdl_delay_chk #(.SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_en  (latch_en),
    .force_min (force_min),
    .force_max (force_max),
    .out_off   (out_off),
    .sel_in    (sel_in),
    .casc_in   (casc_in),
    .code_q    (code_q),
    .casc_hi   (casc_hi),
    .dout      (dout)
);

// File: tb/pdl_delay_top_test.sv
// Bench for pdl_delay_top: directed corners, seeded random codes and a full
// two-copy chain sweep. Expected delays come from the requirement formulas.
module pdl_delay_top_test;

    localparam int SEL_W = 7;
    localparam int TPU   = 4;
    localparam int FIX   = 2;
    localparam int TAPS  = FIX + (TPU / 4) * 127 + TPU;
    localparam int LIMIT = 2 * TAPS + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic [SEL_W-1:0] sel_in = '0;
    logic casc_in = 1'b0;
    logic latch_en = 1'b0;
    logic fmin_a = 1'b0;
    logic fmax_a = 1'b0;
    logic off_a = 1'b0;
    logic q_a, chi_a, clo_a;
    logic q_b, chi_b, clo_b;

    int checks = 0;
    int failures = 0;
    int meas;

    always #4 clk = ~clk;

    pdl_delay_top #(.SEL_W(SEL_W), .TICKS_PER_UNIT(TPU), .FIXED_TAPS(FIX)) uut (
        .clk(clk), .rst_n(rst_n), .din(din), .sel_in(sel_in), .casc_in(casc_in),
        .latch_en(latch_en), .force_min(fmin_a), .force_max(fmax_a),
        .out_off(off_a), .dout(q_a), .casc_hi(chi_a), .casc_lo(clo_a)
    );

    pdl_delay_top #(.SEL_W(SEL_W), .TICKS_PER_UNIT(TPU), .FIXED_TAPS(FIX)) uut_next (
        .clk(clk), .rst_n(rst_n), .din(q_a), .sel_in(sel_in), .casc_in(1'b0),
        .latch_en(latch_en), .force_min(clo_a), .force_max(1'b0),
        .out_off(1'b0), .dout(q_b), .casc_hi(chi_b), .casc_lo(clo_b)
    );

    function automatic int exp_single(input int code);
        return FIX + code;
    endfunction

    function automatic int exp_chain(input int setting);
        return 2 * FIX + setting;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Load a code and cascade bit with one enabled cycle, then settle.
    task automatic set_cfg(input int code, input bit cb);
        @(negedge clk);
        sel_in   = SEL_W'(code);
        casc_in  = cb;
        latch_en = 1'b1;
        @(negedge clk);
        latch_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Send a one-tick pulse; return ticks until it appears, or -1.
    task automatic measure(input bit from_b, output int d);
        int cnt;
        @(negedge clk);
        din = 1'b1;
        @(negedge clk);
        din = 1'b0;
        cnt = 1;
        while (!(from_b ? q_b : q_a) && cnt < LIMIT) begin
            @(negedge clk);
            cnt++;
        end
        d = (from_b ? q_b : q_a) ? cnt : -1;
        repeat (TAPS + 4) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 dout", int'(q_a), 0);
        chk("R9 casc_hi", int'(chi_a), 0);
        chk("R9 casc_lo", int'(clo_a), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: zero code and all-ones code
        set_cfg(0, 0);
        measure(0, meas); chk("R1 code0", meas, exp_single(0));
        set_cfg(127, 0);
        measure(0, meas); chk("R1 code127", meas, exp_single(127));
        // R1: each single weight bit
        for (int k = 0; k < SEL_W; k++) begin
            set_cfg(1 << k, 0);
            measure(0, meas); chk("R1 weight", meas, exp_single(1 << k));
        end

        // R3: cascade pair follows latched bit
        set_cfg(5, 1);
        chk("R3 casc_hi set", int'(chi_a), 1);
        chk("R3 casc_lo set", int'(clo_a), 0);
        set_cfg(5, 0);
        chk("R3 casc_hi clr", int'(chi_a), 0);
        chk("R3 casc_lo clr", int'(clo_a), 1);

        // R2: hold while latch closed, bus changes ignored
        set_cfg(37, 0);
        @(negedge clk); sel_in = 7'd90; casc_in = 1'b1;
        repeat (2) @(negedge clk);
        measure(0, meas); chk("R2 hold", meas, exp_single(37));
        chk("R2 hold casc", int'(chi_a), 0);
        // R2: transparent while enabled
        @(negedge clk); sel_in = 7'd10; casc_in = 1'b0; latch_en = 1'b1;
        repeat (2) @(negedge clk);
        measure(0, meas); chk("R2 transparent", meas, exp_single(10));
        latch_en = 1'b0;

        // R4: minimum override, bus ignored while held
        set_cfg(100, 1);
        @(negedge clk); fmin_a = 1'b1; latch_en = 1'b1; sel_in = 7'd55;
        repeat (2) @(negedge clk);
        measure(0, meas); chk("R4 forced min", meas, exp_single(0));
        chk("R4 casc cleared", int'(chi_a), 0);
        latch_en = 1'b0;
        @(negedge clk); fmin_a = 1'b0;
        repeat (2) @(negedge clk);
        measure(0, meas); chk("R4 kept after release", meas, exp_single(0));

        // R5: maximum override adds the extra unit
        @(negedge clk); fmax_a = 1'b1;
        repeat (2) @(negedge clk);
        measure(0, meas); chk("R5 forced max", meas, exp_single(128));
        chk("R5 casc set", int'(chi_a), 1);
        @(negedge clk); fmax_a = 1'b0;
        repeat (2) @(negedge clk);
        measure(0, meas); chk("R5 after release", meas, exp_single(124));

        // R6: both overrides, minimum wins
        @(negedge clk); fmax_a = 1'b1; fmin_a = 1'b1;
        repeat (2) @(negedge clk);
        measure(0, meas); chk("R6 min priority", meas, exp_single(0));
        chk("R6 casc", int'(chi_a), 0);
        @(negedge clk); fmax_a = 1'b0; fmin_a = 1'b0;

        // R7: output off blocks the pulse
        set_cfg(20, 0);
        @(negedge clk); off_a = 1'b1;
        measure(0, meas); chk("R7 gated", meas, -1);
        @(negedge clk); off_a = 1'b0;
        measure(0, meas); chk("R7 ungated", meas, exp_single(20));

        // R1: seeded random codes
        for (int i = 0; i < 30; i++) begin
            int c;
            c = int'($urandom_range(127, 0));
            set_cfg(c, 0);
            measure(0, meas); chk("R1 random", meas, exp_single(c));
        end

        // R8: full chain sweep, one tick per step
        for (int s = 0; s < 256; s++) begin
            @(negedge clk); fmax_a = s[7];
            set_cfg(s & 127, s[7]);
            measure(1, meas); chk("R8 chain", meas, exp_chain(s));
        end
        @(negedge clk); fmax_a = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule